// File: doc/BRIEF.md
# Indirect RAM Register Access Port

This block lets a processor reach a small word-organised RAM that sits outside its address space. The processor sees four registers on a simple single-cycle register bus. Two of them are address registers: one holds the write pointer and one holds the read pointer. The other two are data ports. One data port accesses the RAM word at a fixed pointer. The other steps its pointer by one word after every access, so blocks can be moved back to back without reloading the pointer.

Read data is never fetched at the moment of the bus read. A prefetch register is reloaded from the RAM whenever the read pointer changes, either by an explicit load or by an auto-increment, and every data-port read returns that register in the same cycle. As a result, a word written to the location under the current read pointer stays invisible until the read pointer is pointed at that location again.

The bus is a register interface, not a stream. Every access completes in the cycle it is presented, and there is no back-pressure. At most one of the write strobe and the read strobe is used per cycle; if both are high, the write wins and the read has no side effect.

Top module: `indirect_ram_port`

## Requirements
- R1: After reset both pointers, both wrap flags, both mode bits and the prefetch register are zero, so reads of all four registers return 0.
- R2: Register offsets are 0 = write address, 1 = read address, 2 = fixed data port, 3 = stepping data port. A bus write to an address register with byte enable 0 set loads its pointer from wdata[ADDR_W-1:0] and clears its wrap flag. The mode bit is left unchanged. A load of the read address also refreshes the prefetch register with the word at the new pointer, visible in the next cycle.
- R3: A write to the fixed data port with byte enable 0 set stores the word at the write pointer, leaves the pointer unchanged and clears the write mode bit.
- R4: A write to the stepping data port with byte enable 0 set stores the word at the write pointer, then increments the pointer by one and sets the write mode bit.
- R5: A write to a data port with byte enable 0 clear is ignored completely: no RAM change, no pointer step, no mode change. With byte enable 0 set, only the bytes whose enables are set are written.
- R6: An increment from the all-ones pointer value wraps the pointer to zero and sets the wrap flag. The flag stays set until the pointer is loaded through its address register.
- R7: A read of the fixed data port returns the prefetch register, keeps the read pointer and clears the read mode bit.
- R8: A read of the stepping data port returns the prefetch register (the word at the old pointer). It then increments the read pointer, sets the read mode bit, wraps as in R6 with its own read wrap flag, and refreshes the prefetch register from the new pointer.
- R9: The prefetch register changes only on a read pointer load or step. A RAM write to the location under the current read pointer is not returned until the read pointer is updated again.
- R10: A read of an address register returns the pointer in bits [ADDR_W-1:0], the wrap flag in bit DATA_W-2, the mode bit in bit DATA_W-1 and zero elsewhere. Such a read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| bus_addr | input | 2 | Register offset |
| bus_be | input | DATA_W/8 | Byte enables for a write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register, combinational |

## Verification
The bench builds the block with 16-bit words and a 4-bit pointer, giving 16 RAM words. With this size both pointers reach the all-ones value and wrap within a few accesses, so the sticky flags, their clearing by a pointer load and the byte-lane merge are exercised many times. A long random mix of loads, fixed and stepping accesses and partial byte enables then checks the stale-prefetch rule against a bench model.

// File: rtl/irp_pkg.sv
package irp_pkg;

  typedef enum logic [1:0] {
    REG_WADDR = 2'd0,
    REG_RADDR = 2'd1,
    REG_DATA0 = 2'd2,
    REG_DATA1 = 2'd3
  } irp_reg_e;

  // Per-pointer control decoded from one bus access
  typedef struct packed {
    logic load;  // address register written
    logic step;  // stepping data port used
    logic fix;   // fixed data port used
  } irp_ptr_ctl_t;

endpackage

// File: rtl/irp_bus_decode.sv
module irp_bus_decode
  import irp_pkg::*;
(
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic         be_low,
  output irp_ptr_ctl_t w_ctl,
  output irp_ptr_ctl_t r_ctl,
  output logic         mem_we
);

  logic wr_ok;
  logic rd_ok;

  // A write needs the low byte lane; a read is dropped when a write is present
  assign wr_ok = bus_wr & be_low;
  assign rd_ok = bus_rd & ~bus_wr;

  always_comb begin
    w_ctl.load = wr_ok && (bus_addr == REG_WADDR);
    w_ctl.fix  = wr_ok && (bus_addr == REG_DATA0);
    w_ctl.step = wr_ok && (bus_addr == REG_DATA1);
    r_ctl.load = wr_ok && (bus_addr == REG_RADDR);
    r_ctl.fix  = rd_ok && (bus_addr == REG_DATA0);
    r_ctl.step = rd_ok && (bus_addr == REG_DATA1);
  end

  assign mem_we = w_ctl.fix | w_ctl.step;

endmodule

// File: rtl/irp_ptr.sv
module irp_ptr
  import irp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irp_ptr_ctl_t      ctl,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrap,
  output logic              mode
);

  localparam logic [ADDR_W-1:0] PTR_MAX = '1;

  logic [ADDR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (ctl.load)      ptr_nxt = load_val;
    else if (ctl.step) ptr_nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      wrap <= 1'b0;
      mode <= 1'b0;
    end else begin
      ptr <= ptr_nxt;
      if (ctl.load)                          wrap <= 1'b0;
      else if (ctl.step && ptr == PTR_MAX)   wrap <= 1'b1;
      if (ctl.step)     mode <= 1'b1;
      else if (ctl.fix) mode <= 1'b0;
    end
  end

endmodule

// File: rtl/irp_store.sv
module irp_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                re,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DATA_W-1:0]   rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  // One byte-wide array and one prefetch byte per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];
    logic [7:0] pf_q;

    always_ff @(posedge clk) begin
      if (we && be[g]) cells[waddr] <= wdata[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pf_q <= '0;
      else if (re) pf_q <= cells[raddr];
    end

    assign rdata[g*8 +: 8] = pf_q;
  end

endmodule

// File: rtl/indirect_ram_port.sv
module indirect_ram_port
  import irp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int BE_W = DATA_W / 8;

  irp_ptr_ctl_t      w_ctl;
  irp_ptr_ctl_t      r_ctl;
  logic              mem_we;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0] rptr;
  logic              wwrap;
  logic              rwrap;
  logic              wmode;
  logic              rmode;
  logic              pf_re;
  logic [ADDR_W-1:0] pf_addr;
  logic [DATA_W-1:0] prefetch;
  logic [DATA_W-1:0] wstat;
  logic [DATA_W-1:0] rstat;

  irp_bus_decode u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .be_low  (bus_be[0]),
    .w_ctl   (w_ctl),
    .r_ctl   (r_ctl),
    .mem_we  (mem_we)
  );

  irp_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (w_ctl),
    .load_val(bus_wdata[ADDR_W-1:0]),
    .ptr     (wptr),
    .wrap    (wwrap),
    .mode    (wmode)
  );

  irp_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (r_ctl),
    .load_val(bus_wdata[ADDR_W-1:0]),
    .ptr     (rptr),
    .wrap    (rwrap),
    .mode    (rmode)
  );

  // Prefetch follows the value the read pointer takes at this edge
  assign pf_re   = r_ctl.load | r_ctl.step;
  assign pf_addr = r_ctl.load ? bus_wdata[ADDR_W-1:0] : rptr + 1'b1;

  irp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .be   (bus_be[BE_W-1:0]),
    .waddr(wptr),
    .wdata(bus_wdata),
    .re   (pf_re),
    .raddr(pf_addr),
    .rdata(prefetch)
  );

  always_comb begin
    wstat = '0;
    wstat[ADDR_W-1:0] = wptr;
    wstat[DATA_W-2]   = wwrap;
    wstat[DATA_W-1]   = wmode;
    rstat = '0;
    rstat[ADDR_W-1:0] = rptr;
    rstat[DATA_W-2]   = rwrap;
    rstat[DATA_W-1]   = rmode;
  end

  always_comb begin
    unique case (bus_addr)
      REG_WADDR: bus_rdata = wstat;
      REG_RADDR: bus_rdata = rstat;
      default:   bus_rdata = prefetch;
    endcase
  end

endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic              be_low,
  input logic [ADDR_W-1:0] wd_ptr,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W-1:0] rptr,
  input logic              wwrap,
  input logic              rwrap,
  input logic              wmode,
  input logic              rmode,
  input logic [DATA_W-1:0] prefetch
);

  localparam logic [ADDR_W-1:0] PMAX = '1;

  logic wr_fix, wr_blk, wr_hi_only, ld_w, ld_r, rd_fix, rd_blk;

  assign wr_fix     = bus_wr && be_low && bus_addr == 2'd2;
  assign wr_blk     = bus_wr && be_low && bus_addr == 2'd3;
  assign wr_hi_only = bus_wr && !be_low && bus_addr[1];
  assign ld_w       = bus_wr && be_low && bus_addr == 2'd0;
  assign ld_r       = bus_wr && be_low && bus_addr == 2'd1;
  assign rd_fix     = bus_rd && !bus_wr && bus_addr == 2'd2;
  assign rd_blk     = bus_rd && !bus_wr && bus_addr == 2'd3;

  AST_WADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> (wptr == $past(wd_ptr)) && !wwrap); // R2
  AST_FIX_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fix |=> (wptr == $past(wptr)) && !wmode); // R3
  AST_BLK_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blk |=> (wptr == $past(wptr) + 1'b1) && wmode); // R4
  AST_HI_ONLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_only |=> $stable(wptr) && $stable(wmode) && $stable(wwrap)); // R5
  AST_WWRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blk && wptr == PMAX) |=> wwrap); // R6
  AST_WWRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wwrap && !ld_w) |=> wwrap); // R6
  AST_RWRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rwrap && !ld_r) |=> rwrap); // R8
  AST_FIX_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fix |=> $stable(rptr) && !rmode); // R7
  AST_BLK_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blk |=> (rptr == $past(rptr) + 1'b1) && rmode); // R8
  AST_PREFETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_r && !rd_blk) |=> $stable(prefetch)); // R9

endmodule

bind indirect_ram_port irp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr),
  .be_low  (bus_be[0]),
  .wd_ptr  (bus_wdata[ADDR_W-1:0]),
  .wptr    (wptr),
  .rptr    (rptr),
  .wwrap   (wwrap),
  .rwrap   (rwrap),
  .wmode   (wmode),
  .rmode   (rmode),
  .prefetch(prefetch)
);

// File: tb/indirect_ram_port_test.sv
module indirect_ram_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [1:0]    bus_be = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench model
  logic [DW-1:0] mem_m [NW];
  logic [AW-1:0] wptr_m = '0, rptr_m = '0;
  logic          wwrap_m = 0, rwrap_m = 0, wmode_m = 0, rmode_m = 0;
  logic [DW-1:0] pf_m = '0;

  indirect_ram_port #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] stat(input logic [AW-1:0] p, input logic w, input logic m);
    logic [DW-1:0] s = '0;
    s[AW-1:0] = p;
    s[DW-2] = w;
    s[DW-1] = m;
    return s;
  endfunction

  function automatic logic [DW-1:0] rd_exp(input logic [1:0] a);
    case (a)
      2'd0:    return stat(wptr_m, wwrap_m, wmode_m);
      2'd1:    return stat(rptr_m, rwrap_m, rmode_m);
      default: return pf_m;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] a, input logic [1:0] be, input logic [DW-1:0] d);
    if (!be[0]) return;
    case (a)
      2'd0: begin wptr_m = d[AW-1:0]; wwrap_m = 0; end
      2'd1: begin rptr_m = d[AW-1:0]; rwrap_m = 0; pf_m = mem_m[rptr_m]; end
      default: begin
        mem_m[wptr_m][7:0] = d[7:0];
        if (be[1]) mem_m[wptr_m][15:8] = d[15:8];
        if (a == 2'd2) wmode_m = 0;
        else begin
          if (wptr_m == '1) wwrap_m = 1;
          wptr_m = wptr_m + 1'b1;
          wmode_m = 1;
        end
      end
    endcase
  endtask

  task automatic model_read(input logic [1:0] a);
    if (a == 2'd2) rmode_m = 0;
    if (a == 2'd3) begin
      if (rptr_m == '1) rwrap_m = 1;
      rptr_m = rptr_m + 1'b1;
      rmode_m = 1;
      pf_m = mem_m[rptr_m];
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [1:0] be, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    model_write(a, be, d);
    #1 bus_wr = 0;
  endtask

  task automatic do_read(input logic [1:0] a, input string tag, output logic [DW-1:0] got);
    @(negedge clk);
    bus_rd = 1; bus_wr = 0; bus_addr = a;
    #1 got = bus_rdata;
    check(tag, got, rd_exp(a));
    @(posedge clk);
    model_read(a);
    #1 bus_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      do_read(2'(a), "R1", v);
      check("R1", v, '0);
    end

    // R4 fill all words with the stepping port; R6 wrap at the end
    do_write(2'd0, 2'b11, 16'h0000);
    for (int i = 0; i < NW; i++) do_write(2'd3, 2'b11, 16'h1000 + 16'(i) * 16'h0101);
    do_read(2'd0, "R6", v);
    check("R6", v, 16'hC000);

    // R5: upper-byte-only write to a data port is ignored
    do_write(2'd2, 2'b10, 16'hFFFF);
    do_read(2'd0, "R5", v);
    check("R5", v, 16'hC000);
    do_write(2'd1, 2'b11, 16'h0000);
    do_read(2'd2, "R5", v);
    check("R5", v, 16'h1000);

    // R2: load clears wrap, keeps mode
    do_write(2'd0, 2'b11, 16'h0005);
    do_read(2'd0, "R2", v);
    check("R2", v, 16'h8005);

    // R3 fixed writes, R5 byte merge
    do_write(2'd2, 2'b11, 16'hABCD);
    do_write(2'd2, 2'b01, 16'h5512);
    do_read(2'd0, "R3", v);
    check("R3", v, 16'h0005);
    do_write(2'd1, 2'b11, 16'h0005);
    do_read(2'd2, "R5", v);
    check("R5", v, 16'hAB12);

    // R9: stale prefetch until the read pointer is reloaded
    do_write(2'd2, 2'b11, 16'h7777);
    do_read(2'd2, "R9", v);
    check("R9", v, 16'hAB12);
    do_write(2'd1, 2'b11, 16'h0005);
    do_read(2'd2, "R9", v);
    check("R9", v, 16'h7777);

    // R8 read wrap, R7 fixed read clears mode
    do_write(2'd1, 2'b11, 16'h000F);
    do_read(2'd3, "R8", v);
    check("R8", v, 16'h1F0F);
    do_read(2'd1, "R8", v);
    check("R8", v, 16'hC000);
    do_read(2'd2, "R7", v);
    check("R7", v, 16'h1000);
    do_read(2'd1, "R7", v);
    check("R7", v, 16'h4000);

    // random mix; address-register reads check R10
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0)
        do_write(a, 2'($urandom_range(0, 3)), 16'($urandom));
      else
        do_read(a, (a == 2'd0 || a == 2'd1) ? "R10" : (a == 2'd2 ? "R7" : "R8"), v);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule